// File: doc/BRIEF.md
# Split Load/Store Queue Selector

This block is a small queue of pending memory operations sitting in front of a data cache that offers two dedicated ports, one for loads and one for stores. Operations enter through a ready/valid allocation handshake and are placed in the lowest-numbered free slot. Every cycle two independent selectors run side by side: one finds the oldest ready load, the other finds the oldest ready store. Each presents its pick on its own port with the slot number as a tag. Replacing one selector that picks any two operations with two class-specific selectors keeps each select path short.

A store visits the cache twice. It is first sent as a tag-only hit check. Once that check is accepted, the entry waits for a response. A hit response moves it to the write phase and makes it selectable again, this time carrying its data. A miss response leaves it waiting, and a later hit response wakes it after an external refill. A load leaves the queue when the cache accepts it. A store leaves when its write is accepted. A write that the cache refuses (store port not ready) stays in the queue and competes again.

Top module: `lsq_split_select`

## Requirements
- R1: `alloc_ready` is high exactly when at least one of the DEPTH slots is free. An allocation fires when `alloc_valid` and `alloc_ready` are both high. It occupies the lowest-numbered free slot, and that slot number is the tag reported later on the ports. While the queue is full, a request is refused and leaves no trace.
- R2: `ld_valid` is high when any load is held. The load port then presents the load allocated earliest, regardless of slot number.
- R3: `st_valid` is high when any store is not waiting for a response. The store port presents the earliest-allocated such store, whether it is in the check phase or the write phase.
- R4: The load and store selectors are independent. A load and a store can be presented and accepted in the same cycle.
- R5: A new store starts in the check phase and is presented with `st_write`=0. After its check is accepted (`st_valid` and `st_ready`), it is not presented again until a response arrives.
- R6: A response with `rsp_valid`=1 and `rsp_hit`=1 for a waiting store moves it to the write phase. From the next cycle it is selectable with `st_write`=1.
- R7: A response with `rsp_hit`=0 leaves the store waiting and unselectable. A later hit response for the same tag still promotes it.
- R8: A load is freed in the cycle after `ld_valid` and `ld_ready` are both high. A load that is presented but not accepted stays at the head of the load port.
- R9: A write-phase store is freed when it is accepted. A rejected write (`st_ready`=0) stays in the queue with the same address and data and is presented again.
- R10: The port fields (`*_addr`, `st_data`, `*_ctrl`) equal the values given at allocation of the entry named by the port's tag.
- R11: After reset the queue is empty: `alloc_ready`=1, `ld_valid`=0 and `st_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free slot exists |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_addr | input | ADDR_W | Operation address |
| alloc_data | input | DATA_W | Store data (ignored for loads) |
| alloc_ctrl | input | CTRL_W | Control bits carried to the port |
| ld_valid | output | 1 | A load is presented |
| ld_ready | input | 1 | Load port accepts |
| ld_tag | output | IDX_W | Slot of the presented load |
| ld_addr | output | ADDR_W | Load address |
| ld_ctrl | output | CTRL_W | Load control bits |
| st_valid | output | 1 | A store pass is presented |
| st_ready | input | 1 | Store port accepts; low on a write means reject |
| st_write | output | 1 | 0 = hit check, 1 = data write |
| st_tag | output | IDX_W | Slot of the presented store |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| st_ctrl | output | CTRL_W | Store control bits |
| rsp_valid | input | 1 | Hit-check response |
| rsp_tag | input | IDX_W | Slot the response is for |
| rsp_hit | input | 1 | 1 = hit, 0 = miss |

## Verification
The bound checker watches several rules on every cycle. A presented load or store always names a live entry of its own class. The store port's phase matches the entry's phase, and a store waiting for a response is never presented. An accepted check puts the entry into waiting. Accepted loads and accepted writes free their slots, while a rejected write keeps its slot in the write phase. Some behaviours can only be shown by the directed scenarios: oldest-first ordering when slot numbers disagree with allocation order, an older write-phase store beating a younger check-phase store, a miss followed by a later hit, refusal when the queue is full, and reuse of the lowest freed slot.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {
    PH_CHECK = 1'b0,
    PH_WRITE = 1'b1
  } lsq_phase_e;
endpackage

// File: rtl/lsq_free_slot.sv
// Lowest-numbered free slot finder for allocation.
module lsq_free_slot #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic             any_free,
  output logic [IDX_W-1:0] slot,
  output logic [DEPTH-1:0] slot_oh
);
  always_comb begin
    slot    = '0;
    slot_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        slot       = IDX_W'(i);
        slot_oh    = '0;
        slot_oh[i] = 1'b1;
      end
    end
    any_free = ~&busy;
  end
endmodule

// File: rtl/lsq_age_order.sv
// Pairwise age matrix: older_o[r][c] = 1 when slot r was allocated before slot c.
module lsq_age_order #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [DEPTH-1:0] alloc_oh,
  input  logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] older_o [DEPTH]
);
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] older_d [DEPTH];

  always_comb begin
    for (int r = 0; r < DEPTH; r++) begin
      for (int c = 0; c < DEPTH; c++) begin
        if (alloc_oh[r])      older_d[r][c] = 1'b0;
        else if (alloc_oh[c]) older_d[r][c] = live[r];
        else                  older_d[r][c] = older_q[r][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) older_q[r] <= '0;
    end else if (alloc_en) begin
      for (int r = 0; r < DEPTH; r++) older_q[r] <= older_d[r];
    end
  end

  always_comb begin
    for (int r = 0; r < DEPTH; r++) older_o[r] = older_q[r];
  end
endmodule

// File: rtl/lsq_oldest_pick.sv
// Picks the requester that no other requester is older than.
module lsq_oldest_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [DEPTH-1:0] older [DEPTH],
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [DEPTH-1:0] win;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      win[i] = req[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && req[j] && older[j][i]) win[i] = 1'b0;
      end
    end
    gnt_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i]) gnt_idx = gnt_idx | IDX_W'(i);
    end
    gnt_any = |win;
  end
endmodule

// File: rtl/lsq_split_select.sv
module lsq_split_select
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int CTRL_W = 24,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_is_store,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic [CTRL_W-1:0] alloc_ctrl,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [IDX_W-1:0]  ld_tag,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [CTRL_W-1:0] ld_ctrl,
  output logic              st_valid,
  input  logic              st_ready,
  output logic              st_write,
  output logic [IDX_W-1:0]  st_tag,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic [CTRL_W-1:0] st_ctrl,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_tag,
  input  logic              rsp_hit
);
  // Per-entry flags
  logic [DEPTH-1:0] valid_q, valid_d;
  logic [DEPTH-1:0] is_store_q, is_store_d;
  logic [DEPTH-1:0] phase_q, phase_d;
  logic [DEPTH-1:0] wait_q, wait_d;

  // Per-entry payload
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [CTRL_W-1:0] ctrl_q [DEPTH];

  logic             free_any;
  logic [IDX_W-1:0] free_slot;
  logic [DEPTH-1:0] free_oh;
  logic [DEPTH-1:0] older [DEPTH];
  logic [DEPTH-1:0] ld_req, st_req;
  logic             alloc_fire, ld_fire, st_fire;
  logic [DEPTH-1:0] pay_we;

  lsq_free_slot #(.DEPTH(DEPTH)) i_free (
    .busy     (valid_q),
    .any_free (free_any),
    .slot     (free_slot),
    .slot_oh  (free_oh)
  );

  assign alloc_ready = free_any;
  assign alloc_fire  = alloc_valid & alloc_ready;

  lsq_age_order #(.DEPTH(DEPTH)) i_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_fire),
    .alloc_oh (free_oh),
    .live     (valid_q),
    .older_o  (older)
  );

  // Two independent class-specific selectors
  assign ld_req = valid_q & ~is_store_q;
  assign st_req = valid_q & is_store_q & ~wait_q;

  lsq_oldest_pick #(.DEPTH(DEPTH)) i_ld_pick (
    .req     (ld_req),
    .older   (older),
    .gnt_any (ld_valid),
    .gnt_idx (ld_tag)
  );

  lsq_oldest_pick #(.DEPTH(DEPTH)) i_st_pick (
    .req     (st_req),
    .older   (older),
    .gnt_any (st_valid),
    .gnt_idx (st_tag)
  );

  assign ld_addr  = addr_q[ld_tag];
  assign ld_ctrl  = ctrl_q[ld_tag];
  assign st_addr  = addr_q[st_tag];
  assign st_data  = data_q[st_tag];
  assign st_ctrl  = ctrl_q[st_tag];
  assign st_write = (phase_q[st_tag] == PH_WRITE);

  assign ld_fire = ld_valid & ld_ready;
  assign st_fire = st_valid & st_ready;
  assign pay_we  = alloc_fire ? free_oh : '0;

  // Next-state logic for entry flags
  always_comb begin
    valid_d    = valid_q;
    is_store_d = is_store_q;
    phase_d    = phase_q;
    wait_d     = wait_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (pay_we[i]) begin
        valid_d[i]    = 1'b1;
        is_store_d[i] = alloc_is_store;
        phase_d[i]    = PH_CHECK;
        wait_d[i]     = 1'b0;
      end
      if (ld_fire && ld_tag == IDX_W'(i)) valid_d[i] = 1'b0;
      if (st_fire && st_tag == IDX_W'(i)) begin
        if (phase_q[i] == PH_WRITE) valid_d[i] = 1'b0;
        else                        wait_d[i]  = 1'b1;
      end
      if (rsp_valid && rsp_hit && rsp_tag == IDX_W'(i) && valid_q[i] && wait_q[i]) begin
        wait_d[i]  = 1'b0;
        phase_d[i] = PH_WRITE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      is_store_q <= '0;
      phase_q    <= '0;
      wait_q     <= '0;
    end else begin
      valid_q    <= valid_d;
      is_store_q <= is_store_d;
      phase_q    <= phase_d;
      wait_q     <= wait_d;
    end
  end

  // Payload storage, written only on allocation into the slot
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pay_we[i]) begin
        addr_q[i] <= alloc_addr;
        data_q[i] <= alloc_data;
        ctrl_q[i] <= alloc_ctrl;
      end
    end
  end
endmodule

// File: rtl/lsq_split_select_chk.sv
module lsq_split_select_chk #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic [IDX_W-1:0] ld_tag,
  input logic             st_valid,
  input logic             st_ready,
  input logic             st_write,
  input logic [IDX_W-1:0] st_tag,
  input logic             rsp_valid,
  input logic [IDX_W-1:0] rsp_tag,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] is_store_q,
  input logic [DEPTH-1:0] phase_q,
  input logic [DEPTH-1:0] wait_q
);
  p_alloc_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (valid_q != '0));

  p_ld_is_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (valid_q[ld_tag] && !is_store_q[ld_tag]));

  p_st_is_ready_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (valid_q[st_tag] && is_store_q[st_tag] && !wait_q[st_tag]));

  p_st_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_write == phase_q[st_tag]));

  p_check_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !st_write) |=> wait_q[$past(st_tag)]);

  p_rsp_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (valid_q[rsp_tag] && wait_q[rsp_tag]));

  p_ld_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !valid_q[$past(ld_tag)]);

  p_write_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_write) |=> !valid_q[$past(st_tag)]);

  p_reject_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready && st_write) |=> (valid_q[$past(st_tag)] && phase_q[$past(st_tag)]));
endmodule

bind lsq_split_select lsq_split_select_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .ld_valid    (ld_valid),
  .ld_ready    (ld_ready),
  .ld_tag      (ld_tag),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .st_write    (st_write),
  .st_tag      (st_tag),
  .rsp_valid   (rsp_valid),
  .rsp_tag     (rsp_tag),
  .valid_q     (valid_q),
  .is_store_q  (is_store_q),
  .phase_q     (phase_q),
  .wait_q      (wait_q)
);

// File: tb/test_lsq_split_select.sv
module test_lsq_split_select;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 64;
  localparam int DATA_W = 64;
  localparam int CTRL_W = 24;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_ready, alloc_is_store;
  logic [ADDR_W-1:0] alloc_addr;
  logic [DATA_W-1:0] alloc_data;
  logic [CTRL_W-1:0] alloc_ctrl;
  logic ld_valid, ld_ready;
  logic [IDX_W-1:0] ld_tag;
  logic [ADDR_W-1:0] ld_addr;
  logic [CTRL_W-1:0] ld_ctrl;
  logic st_valid, st_ready, st_write;
  logic [IDX_W-1:0] st_tag;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic [CTRL_W-1:0] st_ctrl;
  logic rsp_valid, rsp_hit;
  logic [IDX_W-1:0] rsp_tag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsq_split_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W))
  i_lsq_split_select (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_is_store(alloc_is_store),
    .alloc_addr(alloc_addr), .alloc_data(alloc_data), .alloc_ctrl(alloc_ctrl),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_ctrl(ld_ctrl),
    .st_valid(st_valid), .st_ready(st_ready), .st_write(st_write), .st_tag(st_tag),
    .st_addr(st_addr), .st_data(st_data), .st_ctrl(st_ctrl),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One clock edge; returns at the falling edge with outputs settled.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic alloc(input bit is_st, input logic [63:0] a, input logic [63:0] d,
                       input logic [23:0] c);
    alloc_valid = 1'b1; alloc_is_store = is_st;
    alloc_addr = a; alloc_data = d; alloc_ctrl = c;
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic take_load();
    ld_ready = 1'b1; step(); ld_ready = 1'b0;
  endtask

  task automatic take_store();
    st_ready = 1'b1; step(); st_ready = 1'b0;
  endtask

  task automatic respond(input logic [IDX_W-1:0] t, input bit hit);
    rsp_valid = 1'b1; rsp_tag = t; rsp_hit = hit; step(); rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R11 ld_valid", 64'(ld_valid), 64'd0);
    chk("R11 st_valid", 64'(st_valid), 64'd0);
  endtask

  task automatic t_load_order();
    alloc(1'b0, 64'h100, 64'h0, 24'hA1);  // slot 0
    alloc(1'b0, 64'h200, 64'h0, 24'hA2);  // slot 1
    alloc(1'b0, 64'h300, 64'h0, 24'hA3);  // slot 2
    chk("R2 ld_tag oldest", 64'(ld_tag), 64'd0);
    chk("R10 ld_addr", ld_addr, 64'h100);
    chk("R10 ld_ctrl", 64'(ld_ctrl), 64'hA1);
    step();
    chk("R8 not accepted stays", 64'(ld_tag), 64'd0);
    take_load();
    chk("R8 freed after accept", 64'(ld_tag), 64'd1);
    chk("R10 ld_addr next", ld_addr, 64'h200);
    alloc(1'b0, 64'h400, 64'h0, 24'hA4);  // reuses slot 0 but youngest
    chk("R2 age beats slot number", 64'(ld_tag), 64'd1);
    take_load();
    chk("R2 third oldest", 64'(ld_tag), 64'd2);
    take_load();
    chk("R2 youngest in slot 0", 64'(ld_tag), 64'd0);
    chk("R10 ld_addr youngest", ld_addr, 64'h400);
    take_load();
    chk("R8 queue drained", 64'(ld_valid), 64'd0);
  endtask

  task automatic t_store_flow();
    alloc(1'b1, 64'hA0, 64'hD0, 24'hC5);  // slot 0
    chk("R5 st_valid", 64'(st_valid), 64'd1);
    chk("R5 check phase", 64'(st_write), 64'd0);
    chk("R10 st_addr", st_addr, 64'hA0);
    chk("R10 st_ctrl", 64'(st_ctrl), 64'hC5);
    take_store();
    chk("R5 waiting after check", 64'(st_valid), 64'd0);
    respond(4'd0, 1'b0);
    chk("R7 miss keeps waiting", 64'(st_valid), 64'd0);
    step();
    chk("R7 still waiting", 64'(st_valid), 64'd0);
    respond(4'd0, 1'b1);
    chk("R6 write presented", 64'(st_valid), 64'd1);
    chk("R6 write phase", 64'(st_write), 64'd1);
    chk("R10 st_data", st_data, 64'hD0);
    step();
    chk("R9 rejected stays", 64'(st_valid), 64'd1);
    chk("R9 rejected still write", 64'(st_write), 64'd1);
    chk("R9 rejected data", st_data, 64'hD0);
    take_store();
    chk("R9 freed after write", 64'(st_valid), 64'd0);
    alloc(1'b0, 64'h55, 64'h0, 24'h0);
    chk("R9 slot reusable", 64'(ld_tag), 64'd0);
    take_load();
  endtask

  task automatic t_parallel();
    alloc(1'b0, 64'h10, 64'h0, 24'h1);   // slot 0
    alloc(1'b1, 64'h20, 64'hEE, 24'h2);  // slot 1
    chk("R4 load presented", 64'(ld_valid), 64'd1);
    chk("R4 store presented", 64'(st_valid), 64'd1);
    chk("R4 store tag", 64'(st_tag), 64'd1);
    ld_ready = 1'b1; st_ready = 1'b1; step(); ld_ready = 1'b0; st_ready = 1'b0;
    chk("R4 load taken", 64'(ld_valid), 64'd0);
    chk("R4 store taken", 64'(st_valid), 64'd0);
    respond(4'd1, 1'b1);
    chk("R6 write after parallel", 64'(st_write), 64'd1);
    take_store();
    chk("R9 empty after parallel", 64'(st_valid), 64'd0);
  endtask

  task automatic t_store_order();
    alloc(1'b1, 64'h30, 64'h3, 24'h0);  // slot 0
    alloc(1'b1, 64'h40, 64'h4, 24'h0);  // slot 1
    chk("R3 oldest store", 64'(st_tag), 64'd0);
    take_store();
    chk("R3 waiting skipped", 64'(st_tag), 64'd1);
    respond(4'd0, 1'b1);
    chk("R3 older write wins", 64'(st_tag), 64'd0);
    chk("R3 older write phase", 64'(st_write), 64'd1);
    take_store();
    chk("R3 younger check next", 64'(st_tag), 64'd1);
    chk("R3 younger check phase", 64'(st_write), 64'd0);
    take_store();
    respond(4'd1, 1'b1);
    take_store();
    chk("R3 all stores done", 64'(st_valid), 64'd0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) alloc(1'b0, 64'(i * 16 + 16), 64'h0, 24'h0);
    chk("R1 full refuses", 64'(alloc_ready), 64'd0);
    alloc(1'b1, 64'hBAD, 64'hBAD, 24'h0);
    chk("R1 refused store absent", 64'(st_valid), 64'd0);
    take_load();
    chk("R1 space after free", 64'(alloc_ready), 64'd1);
    alloc(1'b0, 64'hF00, 64'h0, 24'h0);   // lowest free slot is 0
    chk("R1 full again", 64'(alloc_ready), 64'd0);
    for (int i = 1; i < DEPTH; i++) begin
      chk("R2 drain order", ld_addr, 64'(i * 16 + 16));
      take_load();
    end
    chk("R1 lowest slot reused", 64'(ld_tag), 64'd0);
    chk("R2 newest last", ld_addr, 64'hF00);
    take_load();
    chk("R8 empty at end", 64'(ld_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_is_store = 1'b0;
    alloc_addr = '0; alloc_data = '0; alloc_ctrl = '0;
    ld_ready = 1'b0; st_ready = 1'b0;
    rsp_valid = 1'b0; rsp_tag = '0; rsp_hit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_order();
    t_store_flow();
    t_parallel();
    t_store_order();
    t_full();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule